// File: doc/BRIEF.md
# Synchronized 8:1 Parallel-to-Serial Converter

This block turns a parallel word into a serial bit stream at the bit-clock rate. Each word goes out least significant bit first. Alongside the stream the block produces a word clock at one eighth of the bit rate. Upstream logic uses that clock to know when the next word is taken in. Every word is latched into an internal holding shift register, so the parallel input only has to be valid around the capture edge.

A single control input, `sync_in`, places every flop of the block in a known state at once, without waiting for a clock edge. The release of `sync_in` is handled in step with the bit clock. After `sync_in` falls, the block waits for a falling bit-clock edge. The rising edge that follows starts the conversion and captures the first word. Because of this, the first serial bit is always a full bit period, and the position of the word boundaries is known in advance. Only the divide-by-eight operating mode is provided.

Top module: `par2ser_sync`

## Requirements
- R1: While `sync_in` is high, `ser_out` is 0, `ser_out_n` is 1 and `word_clk` is 0. These values appear as soon as `sync_in` rises, with no bit-clock edge needed.
- R2: After `sync_in` falls, the first word is captured on the first rising bit-clock edge that follows a falling bit-clock edge seen after the release. If the release comes while the clock is low and after its falling edge, capture happens one bit clock later.
- R3: `par_data[0]` is the first bit sent. Bit i of a word captured on rising edge E is driven on `ser_out` from rising edge E+1+i until the next rising edge.
- R4: A new word is captured every 8 bit clocks with no gap. Bit 7 of one word is followed directly by bit 0 of the next word.
- R5: Changes on `par_data` at any time other than a capture edge have no effect on the bits being sent.
- R6: `ser_out_n` is always the inverse of `ser_out`.
- R7: `word_clk` goes high on each capture edge. It stays high for 4 bit clocks and low for 4, so its period is 8 bit clocks.
- R8: Raising `sync_in` in the middle of a word drops that word. After the next release, framing and the word clock start again from their initial phase.
- R9: `ser_out` changes only on rising bit-clock edges, so no bit is shorter than one bit period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Serial bit clock |
| sync_in | input | 1 | Set high to force the known state at once; released in step with the clock |
| par_data | input | RATIO (8) | Parallel word, bit 0 sent first |
| ser_out | output | 1 | Serial data |
| ser_out_n | output | 1 | Inverse of the serial data |
| word_clk | output | 1 | Word-rate clock, high from each capture edge for half a word |

## Verification
On a capture edge the last bit of the old word leaves the holding register in the same cycle as the next word is loaded into it, and the word clock rises on that same edge. The bench runs several words back to back. It checks that bit 7 of each word sits directly next to bit 0 of the following word, and that the word clock rises exactly at that boundary. A second collision happens when the release of `sync_in` lands either before or after a falling clock edge. The bench releases `sync_in` in each of these two phases and checks that the first capture edge moves by exactly one bit clock.

// File: rtl/par2ser_pkg.sv
package par2ser_pkg;

    localparam int unsigned RATIO_DEF = 8;

    // Width of a counter that walks through r states.
    function automatic int unsigned cnt_bits(input int unsigned r);
        return (r <= 2) ? 1 : $clog2(r);
    endfunction

endpackage

// File: rtl/par2ser_arm.sv
// Release stage: sampled on the falling bit-clock edge, so the first capture
// can only happen on the rising edge that follows it.
module par2ser_arm (
    input  logic bit_clk,
    input  logic sync_in,
    output logic armed_o
);
    logic armed_d;
    logic armed_q;

    always_comb begin
        armed_d = 1'b1;
    end

    always_ff @(negedge bit_clk or posedge sync_in) begin
        if (sync_in) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= armed_d;
        end
    end

    assign armed_o = armed_q;

endmodule

// File: rtl/par2ser_phase.sv
// Word-phase counter and divided word clock.
module par2ser_phase
    import par2ser_pkg::*;
#(
    parameter int unsigned RATIO = RATIO_DEF
) (
    input  logic bit_clk,
    input  logic sync_in,
    input  logic armed_i,
    output logic cap_o,
    output logic word_clk_o
);
    localparam int unsigned CW = cnt_bits(RATIO);
    localparam logic [CW-1:0] LAST = CW'(RATIO - 1);
    localparam logic [CW-1:0] HALF = CW'(RATIO / 2);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          wclk;
    } phase_t;

    phase_t ph_d;
    phase_t ph_q;

    always_comb begin
        ph_d = ph_q;
        if (armed_i) begin
            ph_d.cnt  = (ph_q.cnt == LAST) ? '0 : ph_q.cnt + 1'b1;
            ph_d.wclk = (ph_q.cnt < HALF);
        end
    end

    always_ff @(posedge bit_clk or posedge sync_in) begin
        if (sync_in) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_d;
        end
    end

    assign cap_o      = armed_i && (ph_q.cnt == '0);
    assign word_clk_o = ph_q.wclk;

endmodule

// File: rtl/par2ser_shift.sv
// Holding shift register and registered true/inverse serial outputs.
module par2ser_shift
    import par2ser_pkg::*;
#(
    parameter int unsigned RATIO = RATIO_DEF
) (
    input  logic             bit_clk,
    input  logic             sync_in,
    input  logic             armed_i,
    input  logic             cap_i,
    input  logic [RATIO-1:0] data_i,
    output logic             ser_o,
    output logic             ser_n_o
);
    typedef struct packed {
        logic [RATIO-1:0] shreg;
        logic             ser;
        logic             ser_n;
    } shift_t;

    localparam shift_t SHIFT_RST = '{shreg: '0, ser: 1'b0, ser_n: 1'b1};

    shift_t sh_d;
    shift_t sh_q;

    always_comb begin
        sh_d = sh_q;
        if (armed_i) begin
            sh_d.ser   = sh_q.shreg[0];
            sh_d.ser_n = ~sh_q.shreg[0];
            if (cap_i) begin
                sh_d.shreg = data_i;
            end else begin
                sh_d.shreg = {1'b0, sh_q.shreg[RATIO-1:1]};
            end
        end
    end

    always_ff @(posedge bit_clk or posedge sync_in) begin
        if (sync_in) begin
            sh_q <= SHIFT_RST;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign ser_o   = sh_q.ser;
    assign ser_n_o = sh_q.ser_n;

endmodule

// File: rtl/par2ser_sync.sv
module par2ser_sync
    import par2ser_pkg::*;
#(
    parameter int unsigned RATIO = RATIO_DEF
) (
    input  logic             bit_clk,
    input  logic             sync_in,
    input  logic [RATIO-1:0] par_data,
    output logic             ser_out,
    output logic             ser_out_n,
    output logic             word_clk
);
    logic armed;
    logic cap;

    par2ser_arm arm_i (
        .bit_clk (bit_clk),
        .sync_in (sync_in),
        .armed_o (armed)
    );

    par2ser_phase #(.RATIO(RATIO)) phase_i (
        .bit_clk    (bit_clk),
        .sync_in    (sync_in),
        .armed_i    (armed),
        .cap_o      (cap),
        .word_clk_o (word_clk)
    );

    par2ser_shift #(.RATIO(RATIO)) shift_i (
        .bit_clk (bit_clk),
        .sync_in (sync_in),
        .armed_i (armed),
        .cap_i   (cap),
        .data_i  (par_data),
        .ser_o   (ser_out),
        .ser_n_o (ser_out_n)
    );

endmodule

// File: rtl/par2ser_sync_chk.sv
module par2ser_sync_chk
    import par2ser_pkg::*;
#(
    parameter int unsigned RATIO = RATIO_DEF
) (
    input logic bit_clk,
    input logic sync_in,
    input logic ser_out,
    input logic ser_out_n,
    input logic word_clk
);
    localparam int unsigned CW = cnt_bits(RATIO) + 1;

    logic [CW-1:0] since_q;
    logic          seen_q;
    logic          wprev_q;
    logic          neg_val_q;
    logic          neg_vld_q;

    always_ff @(posedge bit_clk or posedge sync_in) begin
        if (sync_in) begin
            since_q <= '0;
            seen_q  <= 1'b0;
            wprev_q <= 1'b0;
        end else begin
            wprev_q <= word_clk;
            if (word_clk && !wprev_q) begin
                since_q <= '0;
                seen_q  <= 1'b1;
            end else begin
                since_q <= since_q + 1'b1;
            end
        end
    end

    always_ff @(negedge bit_clk or posedge sync_in) begin
        if (sync_in) begin
            neg_val_q <= 1'b0;
            neg_vld_q <= 1'b0;
        end else begin
            neg_val_q <= ser_out;
            neg_vld_q <= 1'b1;
        end
    end

    p_idle_outputs_r1: assert property (@(posedge bit_clk)
        sync_in |-> (!ser_out && ser_out_n && !word_clk));

    p_inverse_r6: assert property (@(posedge bit_clk) disable iff (sync_in)
        ser_out_n == !ser_out);

    p_word_period_r7: assert property (@(posedge bit_clk) disable iff (sync_in)
        (word_clk && !wprev_q && seen_q) |-> (since_q == CW'(RATIO - 1)));

    p_no_runt_r9: assert property (@(posedge bit_clk) disable iff (sync_in)
        neg_vld_q |-> (ser_out == neg_val_q));

endmodule

bind par2ser_sync par2ser_sync_chk #(.RATIO(RATIO)) chk_i (
    .bit_clk   (bit_clk),
    .sync_in   (sync_in),
    .ser_out   (ser_out),
    .ser_out_n (ser_out_n),
    .word_clk  (word_clk)
);

// File: tb/par2ser_sync_tb_top.sv
module par2ser_sync_tb_top;

    logic       clk = 1'b0;
    logic       sync_in;
    logic [7:0] din;
    logic       sout;
    logic       sout_n;
    logic       wclk;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done  = 1'b0;

    always #5 clk = ~clk;

    par2ser_sync #(.RATIO(8)) dut_i (
        .bit_clk   (clk),
        .sync_in   (sync_in),
        .par_data  (din),
        .ser_out   (sout),
        .ser_out_n (sout_n),
        .word_clk  (wclk)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Reset state after power-up with sync held high (R1).
    task automatic t_reset_state();
        sync_in = 1'b1;
        din     = 8'h00;
        repeat (3) @(posedge clk);
        #2;
        check("R1", "ser_out idle", sout, 1'b0);
        check("R1", "ser_out_n idle", sout_n, 1'b1);
        check("R1", "word_clk idle", wclk, 1'b0);
    endtask

    // Release sync, stream up to four words and compare every bit.
    // Entered and left at rising edge + 2 ns with sync high.
    task automatic t_stream(input logic [7:0] w0, input logic [7:0] w1,
                            input logic [7:0] w2, input logic [7:0] w3,
                            input bit late, input int stop_at, input string pre);
        logic [7:0] w [4];
        int         last;
        w[0] = w0; w[1] = w1; w[2] = w2; w[3] = w3;
        last = (stop_at > 0) ? stop_at : 33;
        din  = w[0];
        if (late) begin
            // Release after the falling edge: no capture on the next rising edge (R2).
            #5 sync_in = 1'b0;
            @(posedge clk);
            #2;
            check("R2", {pre, "no capture yet word_clk"}, wclk, 1'b0);
            check("R2", {pre, "no capture yet ser_out"}, sout, 1'b0);
        end else begin
            sync_in = 1'b0;
        end
        for (int n = 1; n <= last; n++) begin
            int   m;
            int   pos;
            logic exp_bit;
            string req;
            @(posedge clk);
            #2;
            if (n == 1) begin
                exp_bit = 1'b0;
                req     = "R2";
            end else begin
                m       = n - 2;
                exp_bit = w[(m / 8) % 4][m % 8];
                if (m % 8 != 0) req = "R5";
                else if (m >= 8) req = "R4";
                else req = "R3";
            end
            check(req, {pre, "ser_out bit"}, sout, exp_bit);
            check("R6", {pre, "ser_out_n"}, sout_n, ~sout);
            check((n == 1) ? "R2" : "R7", {pre, "word_clk phase"}, wclk, ((n - 1) % 8) < 4);
            // Next word must be present before the coming capture edge; scramble otherwise (R5).
            pos = (n - 1) % 8;
            if (pos == 7) din = w[((n - 1) / 8 + 1) % 4];
            else          din = ~w[((n - 1) / 8) % 4] ^ 8'(n * 37);
        end
        // Asynchronous entry into the known state, checked between clock edges (R1, R8).
        sync_in = 1'b1;
        #1;
        check("R1", {pre, "async ser_out"}, sout, 1'b0);
        check("R1", {pre, "async ser_out_n"}, sout_n, 1'b1);
        check("R8", {pre, "async word_clk"}, wclk, 1'b0);
        @(posedge clk);
        #2;
    endtask

    initial begin
        t_reset_state();
        t_stream(8'hA5, 8'h3C, 8'hF0, 8'h01, 1'b0, 0, "R3R4 run: ");
        t_stream(8'h96, 8'h7E, 8'h81, 8'hC3, 1'b1, 0, "R2 late release: ");
        t_stream(8'h55, 8'hAA, 8'h0F, 8'hE7, 1'b0, 13, "R8 abort: ");
        t_stream(8'h12, 8'h34, 8'h56, 8'h78, 1'b0, 0, "R8 restart: ");
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule